// File: doc/BRIEF.md
# Pulse-Width Time-Code Symbol Encoder

This block turns a prepared 100-symbol time-code frame into the unmodulated, DC-level serial waveform of the IRIG-B time code. Each symbol occupies a cell of ten 1 ms ticks, and the symbol's kind sets how long the cell stays high: a binary zero holds the line high for 2 ticks, a binary one for 5 and a marker for 8. The rest of each cell is low. A tick enable at 1 kHz, generated elsewhere from the system clock, paces everything. The block keeps no clock divider of its own.

Frames arrive over a valid/ready stream port, two bits per symbol, into a single holding slot. The slot is ready whenever it is empty. A producer may raise valid at any time and must hold valid and data steady until it sees ready high at a clock edge, which is when the transfer happens. While the slot is full, ready stays low and the producer is back-pressured until the running frame ends and the slot's content moves into the active frame. If the slot is empty when a frame ends, the active frame is sent again and an underrun strobe marks that frame start. Frame content generation and any analog conditioning lie outside this block.

Top module: `tcode_pw_encoder`

## Requirements
- R1: The tick and symbol counters advance only on clock edges where `tick` is high. A symbol cell lasts exactly 10 ticks.
- R2: Symbol code 2'b00 (binary zero) drives `sym_out` high for the first 2 ticks of its cell and low for the remaining 8.
- R3: Symbol code 2'b01 (binary one) drives `sym_out` high for the first 5 ticks of its cell and low for the remaining 5.
- R4: Symbol codes 2'b10 and 2'b11 (marker) drive `sym_out` high for the first 8 ticks of its cell and low for the remaining 2.
- R5: Symbol k of a frame is taken from `frame_data[2k+1:2k]`, and symbol 0 is sent first.
- R6: Every cell starts with a rising edge of `sym_out` in the clock cycle after a tick edge, and `sym_out` changes only in the cycle after a tick edge.
- R7: `frame_ready` is high exactly when the holding slot is empty. A frame transfers on a clock edge with `frame_valid` and `frame_ready` both high. A `frame_valid` while `frame_ready` is low has no effect.
- R8: After reset, `sym_out` stays low and no frame starts until a frame has been accepted. Encoding then starts at the first tick edge after the accepting edge.
- R9: `frame_start` pulses for one cycle, aligned with the first cell of every frame sent.
- R10: After 100 cells, a frame waiting in the holding slot becomes the active frame on the same tick edge, and the slot empties.
- R11: If the slot is empty when a frame ends, the previous frame is sent again and `underrun` pulses together with that `frame_start`.
- R12: While `rst_n` is low, `sym_out`, `frame_start` and `underrun` are low and `frame_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 1 kHz tick enable |
| frame_data | input | 200 | Frame, two bits per symbol, symbol 0 in the low bits |
| frame_valid | input | 1 | Producer offers a frame |
| frame_ready | output | 1 | Holding slot empty, frame can be taken |
| sym_out | output | 1 | Serial pulse-width coded time code |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| underrun | output | 1 | One-cycle strobe when a frame is re-sent |

## Verification
On every cycle, the assertions check these properties: the line stays low while idle, edges of `sym_out` happen only right after a tick, each cell starts high and ends low, the counters hold between ticks and stay in range, and an underrun only occurs at a frame start. The exact high time of each symbol kind, the mapping of symbol bits to cells, and the hand-over of a held frame at the 100-cell boundary can only be shown by the bench. The same applies to the re-send after an underrun and to frames offered while the slot is full being ignored. The bench shows these by comparing every cycle against a tick-level model fed with random and directed frames.

// File: rtl/tcpw_pkg.sv
package tcpw_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO     = 2'b00,
    SYM_ONE      = 2'b01,
    SYM_MARK     = 2'b10,
    SYM_MARK_ALT = 2'b11
  } sym_code_e;
endpackage

// File: rtl/tcpw_cell_timer.sv
module tcpw_cell_timer #(
  parameter int TICKS_PER_CELL = 10,
  parameter int NUM_SYMS       = 100,
  localparam int TW = $clog2(TICKS_PER_CELL),
  localparam int SW = $clog2(NUM_SYMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  output logic          running,
  output logic [TW-1:0] tick_cnt,
  output logic [SW-1:0] sym_idx,
  output logic          frame_go,
  output logic          frame_end
);
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_CELL - 1);
  localparam logic [SW-1:0] LAST_SYM  = SW'(NUM_SYMS - 1);

  logic cell_last;

  assign cell_last = (tick_cnt == LAST_TICK);
  assign frame_go  = tick && !running && start_req;
  assign frame_end = tick && running && cell_last && (sym_idx == LAST_SYM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      tick_cnt <= '0;
      sym_idx  <= '0;
    end else if (tick) begin
      if (!running) begin
        running  <= start_req;
        tick_cnt <= '0;
        sym_idx  <= '0;
      end else if (cell_last) begin
        tick_cnt <= '0;
        sym_idx  <= (sym_idx == LAST_SYM) ? '0 : sym_idx + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcpw_frame_store.sv
module tcpw_frame_store #(
  parameter int NUM_SYMS = 100,
  localparam int FW = 2 * NUM_SYMS,
  localparam int SW = $clog2(NUM_SYMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          take,
  input  logic [SW-1:0] sym_idx,
  output logic          slot_full,
  output logic [1:0]    cur_code
);
  logic [FW-1:0] slot_q;
  logic [FW-1:0] active_q;

  assign in_ready = !slot_full;
  assign cur_code = active_q[{sym_idx, 1'b0} +: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= '0;
      active_q  <= '0;
      slot_full <= 1'b0;
    end else if (take && slot_full) begin
      active_q  <= slot_q;
      slot_full <= 1'b0;
    end else if (in_valid && !slot_full) begin
      slot_q    <= in_data;
      slot_full <= 1'b1;
    end
  end
endmodule

// File: rtl/tcpw_pulse_shaper.sv
module tcpw_pulse_shaper
  import tcpw_pkg::*;
#(
  parameter int TICKS_PER_CELL = 10,
  parameter int ZERO_HIGH      = 2,
  parameter int ONE_HIGH       = 5,
  parameter int MARK_HIGH      = 8,
  localparam int TW = $clog2(TICKS_PER_CELL)
) (
  input  logic          running,
  input  logic [TW-1:0] tick_cnt,
  input  logic [1:0]    code,
  output logic          level
);
  localparam logic [TW:0] ZH = (TW + 1)'(ZERO_HIGH);
  localparam logic [TW:0] OH = (TW + 1)'(ONE_HIGH);
  localparam logic [TW:0] MH = (TW + 1)'(MARK_HIGH);

  logic [TW:0] high_len;

  always_comb begin
    unique case (sym_code_e'(code))
      SYM_ZERO:     high_len = ZH;
      SYM_ONE:      high_len = OH;
      SYM_MARK:     high_len = MH;
      SYM_MARK_ALT: high_len = MH;
      default:      high_len = MH;
    endcase
    level = running && ({1'b0, tick_cnt} < high_len);
  end
endmodule

// File: rtl/tcode_pw_encoder.sv
module tcode_pw_encoder #(
  parameter int NUM_SYMS       = 100,
  parameter int TICKS_PER_CELL = 10,
  parameter int ZERO_HIGH      = 2,
  parameter int ONE_HIGH       = 5,
  parameter int MARK_HIGH      = 8,
  localparam int FW = 2 * NUM_SYMS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [FW-1:0] frame_data,
  input  logic          frame_valid,
  output logic          frame_ready,
  output logic          sym_out,
  output logic          frame_start,
  output logic          underrun
);
  localparam int TW = $clog2(TICKS_PER_CELL);
  localparam int SW = $clog2(NUM_SYMS);

  logic          running;
  logic [TW-1:0] tick_cnt;
  logic [SW-1:0] sym_idx;
  logic          frame_go;
  logic          frame_end;
  logic          slot_full;
  logic [1:0]    cur_code;

  tcpw_cell_timer #(
    .TICKS_PER_CELL(TICKS_PER_CELL),
    .NUM_SYMS      (NUM_SYMS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start_req(slot_full),
    .running  (running),
    .tick_cnt (tick_cnt),
    .sym_idx  (sym_idx),
    .frame_go (frame_go),
    .frame_end(frame_end)
  );

  tcpw_frame_store #(
    .NUM_SYMS(NUM_SYMS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (frame_data),
    .in_valid (frame_valid),
    .in_ready (frame_ready),
    .take     (frame_go || frame_end),
    .sym_idx  (sym_idx),
    .slot_full(slot_full),
    .cur_code (cur_code)
  );

  tcpw_pulse_shaper #(
    .TICKS_PER_CELL(TICKS_PER_CELL),
    .ZERO_HIGH     (ZERO_HIGH),
    .ONE_HIGH      (ONE_HIGH),
    .MARK_HIGH     (MARK_HIGH)
  ) u_shaper (
    .running (running),
    .tick_cnt(tick_cnt),
    .code    (cur_code),
    .level   (sym_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      frame_start <= frame_go || frame_end;
      underrun    <= frame_end && !slot_full;
    end
  end
endmodule

// File: rtl/tcpw_checker.sv
module tcpw_checker #(
  parameter int NUM_SYMS       = 100,
  parameter int TICKS_PER_CELL = 10,
  localparam int TW = $clog2(TICKS_PER_CELL),
  localparam int SW = $clog2(NUM_SYMS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          sym_out,
  input logic          frame_start,
  input logic          underrun,
  input logic          running,
  input logic [TW-1:0] tick_cnt,
  input logic [SW-1:0] sym_idx
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sym_out); // R8

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sym_out) || $fell(sym_out)) |-> $past(tick)); // R6

  AST_CELL_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_cnt == '0) |-> sym_out); // R6

  AST_CELL_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_cnt == TW'(TICKS_PER_CELL - 1)) |-> !sym_out); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tick_cnt) < TICKS_PER_CELL) && (int'(sym_idx) < NUM_SYMS)); // R1

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(tick_cnt) && $stable(sym_idx))); // R1

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (running && tick_cnt == '0 && sym_idx == '0)); // R9

  AST_UNDERRUN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> frame_start); // R11
endmodule

bind tcode_pw_encoder tcpw_checker #(
  .NUM_SYMS      (NUM_SYMS),
  .TICKS_PER_CELL(TICKS_PER_CELL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .sym_out    (sym_out),
  .frame_start(frame_start),
  .underrun   (underrun),
  .running    (running),
  .tick_cnt   (tick_cnt),
  .sym_idx    (sym_idx)
);

// File: tb/tcode_pw_encoder_test.sv
module tcode_pw_encoder_test;
  localparam int NS   = 100;
  localparam int FW   = 2 * NS;
  localparam int DIV  = 4;
  localparam int WDOG = 60000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [FW-1:0] frame_data = '0;
  logic          frame_valid = 1'b0;
  logic          frame_ready;
  logic          sym_out;
  logic          frame_start;
  logic          underrun;

  int checks = 0;
  int fails  = 0;
  int fs_count = 0;
  int ur_count = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tcode_pw_encoder uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_data(frame_data),
    .frame_valid(frame_valid), .frame_ready(frame_ready), .sym_out(sym_out),
    .frame_start(frame_start), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // High time in ticks per symbol code: 00 zero (R2), 01 one (R3), 10/11 marker (R4)
  function automatic int high_of(input logic [1:0] c);
    case (c)
      2'b00:   return 2;
      2'b01:   return 5;
      default: return 8;
    endcase
  endfunction

  // mode 0: random bits; 1: all ones with 2'b11 markers; 2: all zeros
  function automatic logic [FW-1:0] build_frame(input int mode);
    logic [FW-1:0] f;
    for (int k = 0; k < NS; k++) begin
      if (k == 0 || k % 10 == 9) f[2*k +: 2] = (mode == 1) ? 2'b11 : 2'b10;
      else if (mode == 0)        f[2*k +: 2] = {1'b0, 1'($urandom)};
      else if (mode == 1)        f[2*k +: 2] = 2'b01;
      else                       f[2*k +: 2] = 2'b00;
    end
    return f;
  endfunction

  // Tick source: one-cycle pulse every DIV clocks, driven at negedge (R1)
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      tick = (n == DIV - 1) && rst_n;
      n = (n == DIV - 1) ? 0 : n + 1;
    end
  end

  // Tick-level reference model, compared every cycle
  initial begin
    bit            m_run = 0, m_full = 0;
    int            tj = 0, sk = 0;
    logic [FW-1:0] m_act = '0, m_pend = '0;
    bit            tl, vl, rl, go, fe, e_fs, e_ur, e_out;
    logic [FW-1:0] dl;
    rl = 1'b1;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      tl = tick; vl = frame_valid; dl = frame_data;
      @(negedge clk);
      go = tl && !m_run && m_full;
      fe = tl && m_run && tj == 9 && sk == NS - 1;
      e_fs = go || fe;
      e_ur = fe && !m_full;
      if ((go || fe) && m_full) begin m_act = m_pend; m_full = 0; end  // R10
      else if (vl && rl) begin m_pend = dl; m_full = 1; end             // R7
      if (tl) begin
        if (!m_run) begin m_run = go; tj = 0; sk = 0; end
        else if (tj == 9) begin tj = 0; sk = (sk == NS - 1) ? 0 : sk + 1; end
        else tj++;
      end
      e_out = m_run && (tj < high_of(m_act[2*sk +: 2]));
      check(sym_out == e_out, "R2/R3/R4/R5 sym_out", sym_out, e_out);
      check(frame_ready == !m_full, "R7 frame_ready", frame_ready, !m_full);
      check(frame_start == e_fs, "R9 frame_start", frame_start, e_fs);
      check(underrun == e_ur, "R11 underrun", underrun, e_ur);
      if (frame_start) fs_count++;
      if (underrun) ur_count++;
      rl = frame_ready;
    end
  end

  task automatic push(input logic [FW-1:0] f);
    frame_data = f;
    frame_valid = 1'b1;
    while (!frame_ready) @(negedge clk);
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int hi;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R12: outputs under reset
    check(sym_out == 0, "R12 sym_out in reset", sym_out, 0);
    check(frame_ready == 1, "R12 ready in reset", frame_ready, 1);
    check(frame_start == 0 && underrun == 0, "R12 strobes in reset", frame_start, 0);
    rst_n = 1'b1;
    // R8: idle with ticks but no frame, line stays low
    repeat (60) begin
      @(negedge clk);
      check(sym_out == 0 && fs_count == 0, "R8 idle low", sym_out, 0);
    end
    push(build_frame(0));          // frame A, random
    push(build_frame(1));          // frame B, waits for A to go active
    // R7: offer junk while slot full; must be ignored
    frame_data = build_frame(2);
    frame_valid = 1'b1;
    repeat (100) begin
      @(negedge clk);
      check(frame_ready == 0, "R7 ready low while full", frame_ready, 0);
    end
    frame_valid = 1'b0;
    push(build_frame(2));          // frame C, waits for B
    // R3/R4: measure first cell of frame B (2'b11 marker) directly
    wait (fs_count >= 2);
    @(negedge clk);
    hi = 0;
    repeat (10 * DIV) begin
      if (sym_out) hi++;
      @(negedge clk);
    end
    check(hi == 8 * DIV, "R4 marker 2'b11 high time", hi, 8 * DIV);
    wait (fs_count >= 4);          // C started, then re-sent
    check(ur_count == 1, "R11 one underrun after C", ur_count, 1);
    @(negedge clk);
    push(build_frame(0));          // frame D
    wait (fs_count >= 6);
    @(negedge clk);
    check(fs_count == 6, "R9 frame_start count", fs_count, 6);
    check(ur_count == 2, "R11 underrun count", ur_count, 2);
    repeat (40) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d frame starts", fs_count, 6);
    finish_run();
  end
endmodule